// File: doc/BRIEF.md
# Cartridge ROM Bank-Switch Controller

This block sits between a CPU's 8K cartridge window and a 512K flash device. It holds a bank number in a register and places that number above the CPU's 13-bit window offset to form the flash address. The window acts as read-only memory. A CPU write into the window does not reach the flash. Instead it stores a new bank number, taken from address bits 6 down to 1 of the write. The data written plays no part.

Three straps set how the bank number is used. The invert strap selects whether the applied bank is the captured value or its bitwise complement. This decides whether reset selects the lowest or the highest bank. The segment-mode strap narrows switching to 16 banks (128K). In that mode two segment switches supply the top two flash address bits. The flash address is combinational from the CPU address, so it meets the memory's access time with no wait state. The register and the strobe edge detector run on the system clock.

Top module: `cart_bank_mapper`

## Requirements
- R1: While reset is high on a clock edge, the stored bank bits become all zero. The applied bank after reset is therefore 0 with the invert strap low and 63 with it high (full mode).
- R2: On the first clock where `wr_stb` is high after being low, a load takes place if `win_sel` is high and `ld_en_n` is low. The load captures `cpu_addr[6:1]`, and the new bank shows on `flash_addr` from the following cycle.
- R3: With `invert_strap` high, the applied bank is the bitwise complement of the stored bits. With the strap low, the stored bits are applied unchanged.
- R4: A write strobe while `ld_en_n` is high leaves the bank unchanged.
- R5: A write strobe while `win_sel` is low leaves the bank unchanged.
- R6: A strobe held high for several cycles loads only once, at its first cycle. Address changes later in the same strobe are ignored.
- R7: `flash_addr[12:0]` equals `cpu_addr[12:0]` in the same cycle.
- R8: With `seg_mode_strap` low (full mode), `flash_addr[18:13]` is the 6-bit applied bank.
- R9: With `seg_mode_strap` high, `flash_addr[18:17]` equals `seg_sw[1:0]`, and `flash_addr[16:13]` is the low 4 bits of the applied bank.
- R10: `flash_rd_en` is high only when `win_sel` and `rd_stb` are high and `wr_stb` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| win_sel | input | 1 | CPU access targets the cartridge window |
| rd_stb | input | 1 | CPU read strobe |
| wr_stb | input | 1 | CPU write strobe, used as the bank-load trigger |
| ld_en_n | input | 1 | Bank load enable, active low |
| invert_strap | input | 1 | Apply the complement of the stored bank bits |
| seg_mode_strap | input | 1 | Reduced 128K switching with a fixed segment |
| seg_sw | input | 2 | Segment switches for the top flash address bits |
| cpu_addr | input | 13 | CPU address within the window |
| flash_addr | output | 19 | Flash byte address |
| flash_rd_en | output | 1 | Flash output enable, active high |

## Verification
The embedded properties check these on every cycle:
- the register clears under reset;
- the register holds whenever no load qualifies;
- a load captures the presented bits;
- a strobe yields one load pulse;
- the offset passes straight through;
- the read enable stays inside the window and off during writes.

Only the bench's scenarios show the rest: the actual bank numbers seen through the invert and segment straps, the reset bank in each invert setting, and that ignored writes leave the selected bank intact. A behavioural model in the bench also tracks the mapping across a random stream of strap and bus changes.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

    typedef enum logic {
        MAP_FULL    = 1'b0,
        MAP_SEGMENT = 1'b1
    } map_mode_e;

endpackage

// File: rtl/cbm_strobe_edge.sv
module cbm_strobe_edge (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    output logic rise
);

    typedef struct packed {
        logic prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = strobe;
        if (rst) begin
            st_d.prev = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rise = strobe & ~st_q.prev;

    AST_ONE_PULSE_PER_STROBE: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise) else $error("strobe produced two load pulses"); // R6

endmodule

// File: rtl/cbm_bank_reg.sv
module cbm_bank_reg #(
    parameter int BANK_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BANK_W-1:0] din,
    output logic [BANK_W-1:0] bank_q
);

    typedef struct packed {
        logic [BANK_W-1:0] bank;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.bank = '0;
        end else if (load) begin
            st_d.bank = din;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign bank_q = st_q.bank;

    AST_RESET_CLEARS_BANK: assert property (@(posedge clk)
        rst |=> bank_q == '0) else $error("bank not cleared by reset"); // R1

    AST_LOAD_CAPTURES: assert property (@(posedge clk) disable iff (rst)
        load |=> bank_q == $past(din)) else $error("load did not capture"); // R2

    AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(bank_q)) else $error("bank moved without load"); // R4

endmodule

// File: rtl/cbm_addr_map.sv
module cbm_addr_map
    import cbm_pkg::*;
#(
    parameter int OFFS_W = 13,
    parameter int BANK_W = 6,
    parameter int SUB_W  = 4,
    parameter int SEG_W  = 2,
    localparam int ADDR_W = OFFS_W + BANK_W
) (
    input  map_mode_e         mode,
    input  logic              invert,
    input  logic [BANK_W-1:0] bank_raw,
    input  logic [SEG_W-1:0]  seg_sw,
    input  logic [OFFS_W-1:0] offs,
    output logic [ADDR_W-1:0] flash_addr
);

    logic [BANK_W-1:0] bank_eff;
    logic [BANK_W-1:0] bank_seg;

    genvar gi;
    generate
        for (gi = 0; gi < BANK_W; gi++) begin : g_pol
            assign bank_eff[gi] = bank_raw[gi] ^ invert;
        end
        if (SUB_W + SEG_W == BANK_W) begin : g_seg_exact
            assign bank_seg = {seg_sw, bank_eff[SUB_W-1:0]};
        end else begin : g_seg_pad
            assign bank_seg = BANK_W'({seg_sw, bank_eff[SUB_W-1:0]});
        end
    endgenerate

    always_comb begin
        unique case (mode)
            MAP_SEGMENT: flash_addr = {bank_seg, offs};
            default:     flash_addr = {bank_eff, offs};
        endcase
    end

endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
    import cbm_pkg::*;
#(
    parameter int OFFS_W  = 13,
    parameter int BANK_W  = 6,
    parameter int SUB_W   = 4,
    parameter int SEG_W   = 2,
    parameter int CAP_LSB = 1,
    localparam int ADDR_W = OFFS_W + BANK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              win_sel,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic              ld_en_n,
    input  logic              invert_strap,
    input  logic              seg_mode_strap,
    input  logic [SEG_W-1:0]  seg_sw,
    input  logic [OFFS_W-1:0] cpu_addr,
    output logic [ADDR_W-1:0] flash_addr,
    output logic              flash_rd_en
);

    logic              wr_rise;
    logic              load;
    logic [BANK_W-1:0] cap_bits;
    logic [BANK_W-1:0] bank_raw;
    map_mode_e         mode;

    cbm_strobe_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .strobe (wr_stb),
        .rise   (wr_rise)
    );

    assign cap_bits = cpu_addr[CAP_LSB +: BANK_W];
    assign load     = wr_rise & win_sel & ~ld_en_n;

    cbm_bank_reg #(.BANK_W(BANK_W)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .din    (cap_bits),
        .bank_q (bank_raw)
    );

    assign mode = seg_mode_strap ? MAP_SEGMENT : MAP_FULL;

    cbm_addr_map #(
        .OFFS_W (OFFS_W),
        .BANK_W (BANK_W),
        .SUB_W  (SUB_W),
        .SEG_W  (SEG_W)
    ) u_map (
        .mode       (mode),
        .invert     (invert_strap),
        .bank_raw   (bank_raw),
        .seg_sw     (seg_sw),
        .offs       (cpu_addr),
        .flash_addr (flash_addr)
    );

    assign flash_rd_en = win_sel & rd_stb & ~wr_stb;

    AST_RD_ONLY_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        flash_rd_en |-> (win_sel && !wr_stb)) else $error("read enable outside window"); // R10

    AST_OFFSET_PASSES: assert property (@(posedge clk) disable iff (rst)
        flash_addr[OFFS_W-1:0] == cpu_addr) else $error("offset altered"); // R7

    AST_SEGMENT_PINNED: assert property (@(posedge clk) disable iff (rst)
        seg_mode_strap |-> flash_addr[ADDR_W-1 -: SEG_W] == seg_sw) else $error("segment bits wrong"); // R9

    AST_BANK_STEADY_OFF_WINDOW: assert property (@(posedge clk) disable iff (rst)
        !win_sel |=> $stable(bank_raw)) else $error("bank changed by off-window write"); // R5

endmodule

// File: tb/tb_cart_bank_mapper.sv
module tb_cart_bank_mapper;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        win_sel = 1'b0;
    logic        rd_stb = 1'b0;
    logic        wr_stb = 1'b0;
    logic        ld_en_n = 1'b0;
    logic        invert_strap = 1'b0;
    logic        seg_mode_strap = 1'b0;
    logic [1:0]  seg_sw = 2'b00;
    logic [12:0] cpu_addr = 13'h0;
    logic [18:0] flash_addr;
    logic        flash_rd_en;

    int total = 0;
    int bad = 0;
    bit done = 0;

    int m_bank = 0;
    bit m_prev = 0;

    always #4 clk = ~clk;

    cart_bank_mapper dut (
        .clk(clk), .rst(rst), .win_sel(win_sel), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .ld_en_n(ld_en_n), .invert_strap(invert_strap), .seg_mode_strap(seg_mode_strap),
        .seg_sw(seg_sw), .cpu_addr(cpu_addr), .flash_addr(flash_addr), .flash_rd_en(flash_rd_en)
    );

    // Behavioural reference: bank number and previous strobe level
    always @(posedge clk) begin
        if (rst) begin
            m_bank = 0;
            m_prev = 0;
        end else begin
            if (win_sel && wr_stb && !m_prev && !ld_en_n)
                m_bank = (cpu_addr / 2) % 64;
            m_prev = wr_stb;
        end
    end

    function automatic int exp_upper();
        int b;
        b = invert_strap ? (63 - m_bank) : m_bank;
        if (seg_mode_strap) return seg_sw * 16 + (b % 16);
        return b;
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R7", int'(flash_addr[12:0]), int'(cpu_addr));
            chk(seg_mode_strap ? "R9" : "R8", int'(flash_addr[18:13]), exp_upper());
            chk("R10", int'(flash_rd_en), int'(win_sel && rd_stb && !wr_stb));
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic idle();
        win_sel = 0; rd_stb = 0; wr_stb = 0; ld_en_n = 0;
    endtask

    task automatic do_reset();
        rst = 1; idle(); tick(); tick(); rst = 0; #1;
    endtask

    task automatic write_bank(int b, bit win, bit ldn);
        cpu_addr = 13'h0A00 | 13'(b * 2);
        win_sel = win; wr_stb = 1; ld_en_n = ldn; rd_stb = 0;
        tick();
        idle();
        tick();
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        // R1 non-inverted reset -> bank 0
        invert_strap = 0; do_reset();
        chk("R1", int'(flash_addr[18:13]), 0);
        // R1 inverted reset -> bank 63
        invert_strap = 1; do_reset();
        chk("R1", int'(flash_addr[18:13]), 63);

        // R2 load of 37
        invert_strap = 0; do_reset();
        write_bank(37, 1, 0);
        chk("R2", int'(flash_addr[18:13]), 37);
        chk("R8", int'(flash_addr[18:13]), 37);

        // R3 inverted load of 5 -> 58
        invert_strap = 1; do_reset();
        write_bank(5, 1, 0);
        chk("R3", int'(flash_addr[18:13]), 58);
        invert_strap = 0; #1;
        chk("R3", int'(flash_addr[18:13]), 5);

        // R4 load disabled
        write_bank(12, 1, 1);
        chk("R4", int'(flash_addr[18:13]), 5);
        // R5 outside window
        write_bank(20, 0, 0);
        chk("R5", int'(flash_addr[18:13]), 5);

        // R6 held strobe loads once
        cpu_addr = 13'(9 * 2); win_sel = 1; wr_stb = 1; ld_en_n = 0;
        tick();
        cpu_addr = 13'(44 * 2); tick(); tick();
        idle(); tick();
        chk("R6", int'(flash_addr[18:13]), 9);

        // R7 / R10 read in window
        cpu_addr = 13'h1ABC; win_sel = 1; rd_stb = 1; #1;
        chk("R7", int'(flash_addr[12:0]), 'h1ABC);
        chk("R10", int'(flash_rd_en), 1);
        win_sel = 0; #1;
        chk("R10", int'(flash_rd_en), 0);
        win_sel = 1; ld_en_n = 1; wr_stb = 1; #1;
        chk("R10", int'(flash_rd_en), 0);
        tick(); idle(); tick();

        // R9 segment mode: seg 1, bank 43 -> {01,1011} = 27
        write_bank(43, 1, 0);
        chk("R8", int'(flash_addr[18:13]), 43);
        seg_mode_strap = 1; seg_sw = 2'd1; #1;
        chk("R9", int'(flash_addr[18:13]), 27);
        invert_strap = 1; #1;
        chk("R9", int'(flash_addr[18:13]), 20);
        invert_strap = 0; seg_mode_strap = 0; tick();

        // Random traffic against the model
        for (int i = 0; i < 600; i++) begin
            win_sel = 1'($urandom);
            rd_stb = 1'($urandom);
            wr_stb = ($urandom % 3) == 0;
            ld_en_n = ($urandom % 4) == 0;
            cpu_addr = 13'($urandom);
            if ((i % 97) == 0) invert_strap = 1'($urandom);
            if ((i % 61) == 0) seg_mode_strap = 1'($urandom);
            if ((i % 43) == 0) seg_sw = 2'($urandom);
            tick();
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule